// File: doc/BRIEF.md
# Memory Partition Discovery Sequencer

After reset, this block masters a register bus and works out how a partitioned memory subsystem is populated. It reads how many partitions exist and how many partitions form one group. It reads one cache-slice fuse word per group and a floorsweep mask. It then reads the capacity of every partition the mask leaves enabled.

From these reads it decides whether the configuration has mixed density. That is the case when enabled partitions report different sizes, or when groups have different slice coverage. In a mixed configuration it sets a flag bit in a hub control register with a read-modify-write. It then reports a lower address window and an upper address window. Otherwise it issues no write and reports one window that covers the whole capacity.

The bus carries one transaction at a time, with valid/ready on the request and a valid strobe with an error bit on the response. Software or a boot controller pulses `start` and waits for the `done` pulse.

Top module: `mem_partition_probe`

## Requirements
- R1: The first read goes to 0x2243C; bits 4:0 give the partition count, clamped to 16. The second read goes to 0x22458; bits 4:0 give partitions per group, with 0 treated as 1. The group count is the partition count divided by partitions per group, rounded down.
- R2: For each group g below the group count, the block reads a fuse word at 0x21D70 + 4*g. A group's coverage is the number of set bits in its word. Two groups with different coverage make the configuration mixed. Words that differ but have the same bit count do not.
- R3: After the fuse words, the block reads the floorsweep mask at 0x21C14 and uses bits 15:0. Partition i (i below the count) is probed only when mask bit i is 0. Masked partitions are never read and never affect any result.
- R4: The size of partition i is read at 0x900000 + i*0x4000 + 0x20C. Any size that differs among the probed partitions makes the configuration mixed.
- R5: When mixed, the block reads 0x100800 and then writes it back with bit 4 set and all other bits unchanged. When not mixed, it makes no write at all.
- R6: When mixed, the common size is the smallest probed size. The lower window size is common size times the number of probed partitions. The upper base is 0x10_0000_0000 plus the common size. The upper size is the total probed capacity minus the lower size.
- R7: When not mixed, the lower window size equals the total probed capacity, and the upper base and upper size are 0.
- R8: A request holds its valid, address, write flag and data steady until ready is seen. No new request is issued while a response is outstanding.
- R9: An error response ends the sequence. It raises `err_flag` together with `done`, no further requests follow, and all results read 0.
- R10: After reset, `done`, `bus_req_valid` and all results are 0. `done` is a one-cycle pulse, and the results stay valid after it until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin discovery (taken while idle) |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted |
| bus_req_we | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | 32 | Register byte address |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sequence aborted on bus error |
| mixed | output | 1 | Mixed-density configuration found |
| lo_size | output | 40 | Lower window size (base 0) |
| hi_base | output | 40 | Upper window base |
| hi_size | output | 40 | Upper window size |

## Verification
The checker watches the bus protocol on every cycle. It checks that a stalled request holds steady, that every write targets the hub register with bit 4 set, that `done` never coincides with a request, that an error appears only with `done`, and that a non-mixed result has an empty upper window. Only the bench scenarios can show that the address sequence is right and that masked partitions are skipped. They also show that coverage is compared by bit count, that the window arithmetic is correct, and that the read-modify-write preserves the other hub bits. The bench confirms these through its slave model's access counts and its register contents.

// File: rtl/mem_partition_probe.sv
module mem_partition_probe #(
  parameter int MAX_PARTS = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int WIN_W     = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [DATA_W-1:0] bus_rsp_data,
  output logic              done,
  output logic              err_flag,
  output logic              mixed,
  output logic [WIN_W-1:0]  lo_size,
  output logic [WIN_W-1:0]  hi_base,
  output logic [WIN_W-1:0]  hi_size
);
  localparam int IDX_W = $clog2(MAX_PARTS + 1);
  localparam int POP_W = $clog2(DATA_W + 1);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(32'h0002_243C);
  localparam logic [ADDR_W-1:0] A_GROUP = ADDR_W'(32'h0002_2458);
  localparam logic [ADDR_W-1:0] A_SLICE = ADDR_W'(32'h0002_1D70);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(32'h0002_1C14);
  localparam logic [ADDR_W-1:0] A_PART  = ADDR_W'(32'h0090_020C);
  localparam logic [ADDR_W-1:0] A_HUB   = ADDR_W'(32'h0010_0800);
  localparam logic [WIN_W-1:0]  UPPER   = WIN_W'(40'h10_0000_0000);

  typedef enum logic [3:0] {S_IDLE, S_CNT, S_PER, S_SLICE, S_MASK,
                            S_SIZE, S_HUB_RD, S_HUB_WR, S_FIN} st_t;
  st_t st;

  logic                 wait_rsp, mix;
  logic [IDX_W-1:0]     cnt, ngrp, idx, nen;
  logic [2**IDX_W-1:0]  mask;
  logic [POP_W-1:0]     ref_pop;
  logic [DATA_W-1:0]    first_sz, min_sz, hub_val;
  logic [WIN_W-1:0]     total;

  logic [4:0]       raw5;
  logic [IDX_W-1:0] per_val, ngrp_calc;
  logic [POP_W-1:0] pop;
  logic             probe;
  logic [WIN_W-1:0] lo_calc;

  assign raw5      = bus_rsp_data[4:0];
  assign per_val   = (raw5 == 5'd0) ? IDX_W'(1) : IDX_W'(raw5);
  assign ngrp_calc = cnt / per_val;
  assign pop       = POP_W'($countones(bus_rsp_data));
  assign probe     = (st == S_SIZE) && (idx < cnt) && !mask[idx];
  assign lo_calc   = WIN_W'(min_sz) * WIN_W'(nen);

  always_comb begin
    case (st)
      S_CNT:    bus_req_addr = A_COUNT;
      S_PER:    bus_req_addr = A_GROUP;
      S_SLICE:  bus_req_addr = A_SLICE + ADDR_W'({idx, 2'b00});
      S_MASK:   bus_req_addr = A_MASK;
      S_SIZE:   bus_req_addr = A_PART + ADDR_W'({idx, 14'b0});
      default:  bus_req_addr = A_HUB;
    endcase
  end

  assign bus_req_valid = !wait_rsp &&
                         (st inside {S_CNT, S_PER, S_SLICE, S_MASK, S_HUB_RD, S_HUB_WR} || probe);
  assign bus_req_we    = (st == S_HUB_WR);
  assign bus_req_wdata = hub_val | DATA_W'(32'h10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wait_rsp <= 1'b0; mix <= 1'b0;
      cnt <= '0; ngrp <= '0; idx <= '0; nen <= '0; mask <= '0; ref_pop <= '0;
      first_sz <= '0; min_sz <= '0; hub_val <= '0; total <= '0;
      done <= 1'b0; err_flag <= 1'b0; mixed <= 1'b0;
      lo_size <= '0; hi_base <= '0; hi_size <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req_valid && bus_req_ready) wait_rsp <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st <= S_CNT; mix <= 1'b0; idx <= '0; nen <= '0; total <= '0;
          min_sz <= '0; first_sz <= '0;
          err_flag <= 1'b0; mixed <= 1'b0;
          lo_size <= '0; hi_base <= '0; hi_size <= '0;
        end
        S_SIZE: if (!wait_rsp && !probe) begin
          if (idx >= cnt) st <= mix ? S_HUB_RD : S_FIN;
          else idx <= idx + 1'b1;
        end
        S_FIN: begin
          st <= S_IDLE; done <= 1'b1; mixed <= mix;
          if (mix) begin
            lo_size <= lo_calc;
            hi_base <= UPPER + WIN_W'(min_sz);
            hi_size <= total - lo_calc;
          end else begin
            lo_size <= total;
          end
        end
        default: ;
      endcase
      if (wait_rsp && bus_rsp_valid) begin
        wait_rsp <= 1'b0;
        if (bus_rsp_err) begin
          st <= S_IDLE; err_flag <= 1'b1; done <= 1'b1;
        end else begin
          case (st)
            S_CNT: begin
              cnt <= (raw5 > 5'(MAX_PARTS)) ? IDX_W'(MAX_PARTS) : IDX_W'(raw5);
              st  <= S_PER;
            end
            S_PER: begin
              ngrp <= ngrp_calc; idx <= '0;
              st   <= (ngrp_calc == '0) ? S_MASK : S_SLICE;
            end
            S_SLICE: begin
              if (idx == '0) ref_pop <= pop;
              else if (pop != ref_pop) mix <= 1'b1;
              if (idx + 1'b1 == ngrp) begin idx <= '0; st <= S_MASK; end
              else idx <= idx + 1'b1;
            end
            S_MASK: begin
              mask <= (2**IDX_W)'(bus_rsp_data[MAX_PARTS-1:0]);
              idx  <= '0; st <= S_SIZE;
            end
            S_SIZE: begin
              if (nen == '0) begin
                first_sz <= bus_rsp_data; min_sz <= bus_rsp_data;
              end else begin
                if (bus_rsp_data != first_sz) mix <= 1'b1;
                if (bus_rsp_data < min_sz) min_sz <= bus_rsp_data;
              end
              total <= total + WIN_W'(bus_rsp_data);
              nen <= nen + 1'b1; idx <= idx + 1'b1;
            end
            S_HUB_RD: begin hub_val <= bus_rsp_data; st <= S_HUB_WR; end
            S_HUB_WR: st <= S_FIN;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module mem_partition_probe_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_we,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [DATA_W-1:0] bus_req_wdata,
  input logic              done,
  input logic              err_flag,
  input logic              mixed,
  input logic [WIN_W-1:0]  hi_base,
  input logic [WIN_W-1:0]  hi_size
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_we) && $stable(bus_req_wdata));
  // R5
  hub_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_we |-> bus_req_addr == ADDR_W'(32'h0010_0800) && bus_req_wdata[4]);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req_valid);
  // R9
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done);
  // R7
  single_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mixed |-> hi_base == '0 && hi_size == '0);
  // R6
  upper_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mixed |-> hi_base >= WIN_W'(40'h10_0000_0000));
endmodule

bind mem_partition_probe mem_partition_probe_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) chk (.*);

// File: tb/mem_partition_probe_test.sv
module mem_partition_probe_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic req_valid, req_ready = 0, req_we;
  logic [31:0] req_addr, req_wdata;
  logic rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_data = 0;
  logic done, err_flag, mixed;
  logic [39:0] lo_size, hi_base, hi_size;

  always #4 clk = ~clk;

  mem_partition_probe uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_req_valid(req_valid), .bus_req_ready(req_ready), .bus_req_we(req_we),
    .bus_req_addr(req_addr), .bus_req_wdata(req_wdata),
    .bus_rsp_valid(rsp_valid), .bus_rsp_err(rsp_err), .bus_rsp_data(rsp_data),
    .done(done), .err_flag(err_flag), .mixed(mixed),
    .lo_size(lo_size), .hi_base(hi_base), .hi_size(hi_size));

  typedef struct packed {
    logic [4:0]  cnt;
    logic [4:0]  per;
    logic [15:0] mask;
    logic [31:0] sza;
    logic [4:0]  odd;
    logic [31:0] szb;
    logic [4:0]  sodd;
    logic        xmix;
    logic [39:0] xlo;
    logic [39:0] xhb;
    logic [39:0] xhs;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{5'd4,  5'd1, 16'h0000, 32'h1000, 5'd31, 32'h0,    5'd31, 1'b0, 40'h4000, 40'h0, 40'h0},
    '{5'd4,  5'd2, 16'h0000, 32'h1000, 5'd2,  32'h2000, 5'd31, 1'b1, 40'h4000, 40'h10_0000_1000, 40'h1000},
    '{5'd8,  5'd2, 16'h0005, 32'h0800, 5'd2,  32'h0100, 5'd31, 1'b0, 40'h3000, 40'h0, 40'h0},
    '{5'd4,  5'd2, 16'h0000, 32'h1000, 5'd31, 32'h0,    5'd1,  1'b1, 40'h4000, 40'h10_0000_1000, 40'h0},
    '{5'd16, 5'd2, 16'h8000, 32'h0400, 5'd0,  32'h0200, 5'd31, 1'b1, 40'h1E00, 40'h10_0000_0200, 40'h1C00},
    '{5'd3,  5'd2, 16'h0000, 32'h0010, 5'd1,  32'h0030, 5'd31, 1'b1, 40'h30,   40'h10_0000_0010, 40'h20},
    '{5'd4,  5'd1, 16'h000F, 32'h1000, 5'd31, 32'h0,    5'd31, 1'b0, 40'h0,    40'h0, 40'h0},
    '{5'd20, 5'd4, 16'h0000, 32'h0100, 5'd31, 32'h0,    5'd31, 1'b0, 40'h1000, 40'h0, 40'h0}
  };

  int checks = 0, fails = 0;
  vec_t cfg;
  logic [31:0] hub_reg;
  int reads, writes, accesses, err_at, lat, proto_err, bad_addr, cyc;
  logic [31:0] cap_addr;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] decode(logic [31:0] a);
    logic [4:0] g;
    if (a == 32'h2243C) return {1'b0, 32'hABCD_EFE0 | 32'(cfg.cnt)};
    if (a == 32'h22458) return {1'b0, 32'h1234_5660 | 32'(cfg.per)};
    if (a >= 32'h21D70 && a < 32'h21DB0 && a[1:0] == 2'b00) begin
      g = 5'((a - 32'h21D70) >> 2);
      if (g == cfg.sodd) return {1'b0, 32'h7};
      return {1'b0, g[0] ? 32'hF0 : 32'hF};
    end
    if (a == 32'h21C14) return {1'b0, 16'hFFFF, cfg.mask};
    if (a >= 32'h900000 && a < 32'h940000 && a[13:0] == 14'h20C) begin
      g = 5'((a - 32'h900000) >> 14);
      if (cfg.mask[g[3:0]]) return {1'b1, 32'h0};
      return {1'b0, (g == cfg.odd) ? cfg.szb : cfg.sza};
    end
    if (a == 32'h100800) return {1'b0, hub_reg};
    return {1'b1, 32'h0};
  endfunction

  always @(negedge clk) begin
    logic [32:0] d;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_valid = 0; rsp_err = 0;
    if (!rst_n) begin
      req_ready = 0; lat = 0;
    end else if (req_ready) begin
      req_ready = 0;
      if (req_addr !== cap_addr) proto_err++;
      accesses++;
      d = decode(req_addr);
      if (d[32]) bad_addr++;
      if (req_we) writes++; else reads++;
      if (accesses == err_at) rsp_err = 1;
      else if (req_we) hub_reg = req_wdata;
      rsp_data = d[31:0];
      lat = 1 + int'(lfsr[0]);
      if (rsp_err) begin lat = 0; rsp_valid = 1; end
    end else if (lat != 0) begin
      lat--;
      if (lat == 0) rsp_valid = 1;
    end else if (req_valid && lfsr[3]) begin
      req_ready = 1; cap_addr = req_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_start(output bit ok);
    reads = 0; writes = 0; accesses = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    bit ok;
    int nen, ngrp, c;
    proto_err = 0; bad_addr = 0; err_at = 0; hub_reg = 0; cyc = 0;
    cfg = VEC[0];
    repeat (3) @(negedge clk);
    check("R10 reset done", 64'(done), 0);
    check("R10 reset req_valid", 64'(req_valid), 0);
    check("R10 reset lo_size", 64'(lo_size), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      cfg = VEC[k];
      hub_reg = 32'h0000_0123;
      run_start(ok);
      check("R10 done seen", 64'(ok), 1);
      // R1 R2 R3 R4 R6 R7
      check($sformatf("R4 mixed v%0d", k), 64'(mixed), 64'(cfg.xmix));
      check($sformatf("R6 lo_size v%0d", k), 64'(lo_size), 64'(cfg.xlo));
      check($sformatf("R6 hi_base v%0d", k), 64'(hi_base), 64'(cfg.xhb));
      check($sformatf("R7 hi_size v%0d", k), 64'(hi_size), 64'(cfg.xhs));
      check($sformatf("R9 no error v%0d", k), 64'(err_flag), 0);
      @(negedge clk);
      check("R10 done pulse width", 64'(done), 0);
      check("R10 results held", 64'(lo_size), 64'(cfg.xlo));
      repeat (4) @(negedge clk);
      c = (cfg.cnt > 16) ? 16 : int'(cfg.cnt);
      ngrp = c / ((cfg.per == 0) ? 1 : int'(cfg.per));
      nen = 0;
      for (int i = 0; i < c; i++) if (!cfg.mask[i]) nen++;
      // R1 R2 R3 read sequence length
      check($sformatf("R3 read count v%0d", k), 64'(reads), 64'(3 + ngrp + nen + int'(cfg.xmix)));
      check($sformatf("R5 write count v%0d", k), 64'(writes), 64'(cfg.xmix));
      check($sformatf("R5 hub value v%0d", k), 64'(hub_reg), cfg.xmix ? 64'h133 : 64'h123);
    end

    cfg = VEC[1]; hub_reg = 32'h0000_0123; err_at = 3;
    run_start(ok);
    check("R9 done on error", 64'(ok), 1);
    check("R9 err_flag", 64'(err_flag), 1);
    check("R9 mixed cleared", 64'(mixed), 0);
    check("R9 lo cleared", 64'(lo_size), 0);
    repeat (20) @(negedge clk);
    check("R9 no further requests", 64'(accesses), 3);

    err_at = 11; hub_reg = 32'h0000_0123;
    run_start(ok);
    check("R9 error on write", 64'(err_flag), 1);
    check("R9 hub untouched", 64'(hub_reg), 64'h123);
    err_at = 0;

    cfg = VEC[0];
    run_start(ok);
    check("R9 error cleared by start", 64'(err_flag), 0);
    check("R1 lo after recovery", 64'(lo_size), 64'h4000);

    check("R8 request stable at handshake", 64'(proto_err), 0);
    check("R3 R4 no stray address", 64'(bad_addr), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule